// File: doc/BRIEF.md
# Constant Off-Time Peak-Current Switch Controller

This block is the digital sequencer behind a peak-current buck LED driver. Every input arrives as a one-bit comparator result or a flag, and the block produces a single gate-enable output. It runs one switching cycle after another. Each cycle turns the switch on and masks the sense inputs for a leading-edge blanking window. It then waits for either of two peak comparators, one with a fixed threshold and one with an adjustable threshold, to trip. When one trips, the switch goes off for a programmed constant time. The on time is therefore set by the current reaching its peak, and the switching period is the on time plus the fixed off time.

Several conditions override normal switching. A low dimming-enable level holds the gate off, and switching restarts promptly when the level returns high. An over-temperature flag or an under-voltage flag holds the gate off for as long as it is active. An over-current trip forces a long, separately timed hold-off before a new cycle starts. Blanking and off-time lengths come in as cycle counts on register inputs. The over-current hold-off length is a parameter.

Top module: `cot_switch_ctrl`

## Requirements
- R1: While the gate is on and the blanking window has ended, an active level on either peak input (fixed or adjust) turns the gate off. The two inputs have identical effect, so the lower analog threshold governs.
- R2: For max(B,1) clock cycles after each gate rising edge, where B is `blank_cyc_i`, both peak inputs are ignored. With a peak input held active, the gate stays on for exactly max(B,1)+1 cycles.
- R3: After every gate falling edge caused by a peak trip, the gate stays off for exactly max(T,1) cycles, where T is `toff_cyc_i`, and then rises. Peak pulses that arrive while the gate is off are ignored.
- R4: While no peak, over-current or inhibit input is active, the gate stays on indefinitely once a cycle has begun.
- R5: A low `dim_en_i` forces the gate off at the third rising clock edge counted from the first edge at which the low level is present, and keeps it off. A high level with no fault active raises the gate at the third such edge, starting a new cycle with blanking.
- R6: An active `ocp_i` while the gate is on turns the gate off at the third rising edge counting from the first edge at which it is present. The gate then stays off for exactly OC_HOLD_CYC cycles before a new cycle starts.
- R7: When an over-current trip and a peak trip are seen in the same cycle, the over-current hold-off wins. The off interval is OC_HOLD_CYC cycles, not the programmed off time.
- R8: An active `otp_i` or `uvlo_i` forces the gate off with the same three-edge latency as R5. The gate rises again with the same latency after the flag clears.
- R9: The gate is low while reset is asserted. After reset is released, the first gate-on phase begins with blanking active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| peak_fix_i | input | 1 | Fixed-threshold peak comparator, active high |
| peak_adj_i | input | 1 | Adjustable-threshold peak comparator, active high |
| ocp_i | input | 1 | Over-current comparator, active high |
| dim_en_i | input | 1 | Dimming enable level; low forces gate off |
| otp_i | input | 1 | Over-temperature flag, active high |
| uvlo_i | input | 1 | Under-voltage lockout flag, active high |
| toff_cyc_i | input | CNT_W | Off time in clock cycles |
| blank_cyc_i | input | CNT_W | Blanking window in clock cycles |
| gate_o | output | 1 | Gate enable, high = switch on |

## Verification
The collision that matters most is an over-current trip and a peak trip landing in the same sense cycle. Both try to end the on phase, but they lead to off intervals of very different lengths. The bench pulses both inputs on the same clock while the gate is in its sense phase, with a short programmed off time. It then measures how long the gate stays low: the over-current hold length must appear, not the off time. The same length measurement, taken with each peak input held on its own, is swept over every blanking and off-time setting from 0 to 4.

// File: rtl/cot_pkg.sv
package cot_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BLANK = 3'd1,
    ST_SENSE = 3'd2,
    ST_OFF   = 3'd3,
    ST_HOLD  = 3'd4
  } cot_state_e;
endpackage

// File: rtl/cot_sync.sv
module cot_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/cot_dwell.sv
module cot_dwell #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ld_i) begin
      cnt_d = ld_val_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q <= W'(1));
endmodule

// File: rtl/cot_switch_ctrl.sv
module cot_switch_ctrl
  import cot_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int OC_HOLD_CYC = 1300000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             peak_fix_i,
  input  logic             peak_adj_i,
  input  logic             ocp_i,
  input  logic             dim_en_i,
  input  logic             otp_i,
  input  logic             uvlo_i,
  input  logic [CNT_W-1:0] toff_cyc_i,
  input  logic [CNT_W-1:0] blank_cyc_i,
  output logic             gate_o
);
  localparam int NSYNC  = 6;
  localparam int HOLD_W = $clog2(OC_HOLD_CYC + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NSYNC-1:0] raw_in, syn_in;
  assign raw_in = {peak_fix_i, peak_adj_i, ocp_i, dim_en_i, otp_i, uvlo_i};

  cot_sync #(.W(NSYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  logic pk_hit, ocp_s, dim_s, flt_s, inhibit;
  assign pk_hit  = syn_in[5] | syn_in[4];
  assign ocp_s   = syn_in[3];
  assign dim_s   = syn_in[2];
  assign flt_s   = syn_in[1] | syn_in[0];
  assign inhibit = flt_s | ~dim_s;

  cot_state_e state_q, state_d;
  logic       gate_q, gate_d;
  logic       ph_ld, ph_last, hold_ld, hold_last;
  logic [CNT_W-1:0] ph_val;

  cot_dwell #(.W(CNT_W)) u_phase_tmr (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .ld_i     (ph_ld),
    .ld_val_i (ph_val),
    .last_o   (ph_last)
  );

  cot_dwell #(.W(HOLD_W)) u_hold_tmr (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .ld_i     (hold_ld),
    .ld_val_i (HOLD_W'(OC_HOLD_CYC)),
    .last_o   (hold_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (!inhibit) state_d = ST_BLANK;
      ST_BLANK: begin
        if (ocp_s)        state_d = ST_HOLD;
        else if (inhibit) state_d = ST_IDLE;
        else if (ph_last) state_d = ST_SENSE;
      end
      ST_SENSE: begin
        if (ocp_s)        state_d = ST_HOLD;
        else if (inhibit) state_d = ST_IDLE;
        else if (pk_hit)  state_d = ST_OFF;
      end
      ST_OFF: begin
        if (inhibit)      state_d = ST_IDLE;
        else if (ph_last) state_d = ST_BLANK;
      end
      ST_HOLD: if (hold_last) state_d = inhibit ? ST_IDLE : ST_BLANK;
      default:            state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    gate_d  = (state_d == ST_BLANK) || (state_d == ST_SENSE);
    ph_ld   = (state_d != state_q) &&
              ((state_d == ST_BLANK) || (state_d == ST_OFF));
    ph_val  = (state_d == ST_BLANK) ? blank_cyc_i : toff_cyc_i;
    hold_ld = (state_d == ST_HOLD) && (state_q != ST_HOLD);
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      state_q <= ST_IDLE;
      gate_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      gate_q  <= gate_d;
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/cot_switch_ctrl_chk.sv
module cot_switch_ctrl_chk
  import cot_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input cot_state_e state_q,
  input logic       gate_o,
  input logic       pk_hit,
  input logic       ocp_s,
  input logic       dim_s,
  input logic       flt_s
);
  // R1
  peak_trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SENSE) && pk_hit && !ocp_s && dim_s && !flt_s |=> !gate_o);

  // R2
  blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) && !ocp_s && dim_s && !flt_s |=> gate_o);

  // R3
  off_no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF) |=> (state_q != ST_HOLD));

  // R5
  dim_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dim_s |=> !gate_o);

  // R6
  ocp_hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_s && gate_o |=> (state_q == ST_HOLD) && !gate_o);

  // R8
  fault_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_s |=> !gate_o);
endmodule

bind cot_switch_ctrl cot_switch_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .state_q (state_q),
  .gate_o  (gate_o),
  .pk_hit  (pk_hit),
  .ocp_s   (ocp_s),
  .dim_s   (dim_s),
  .flt_s   (flt_s)
);

// File: tb/cot_switch_ctrl_tb.sv
module cot_switch_ctrl_tb;
  localparam int CNT_W = 16;
  localparam int HOLD  = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic peak_fix, peak_adj, ocp, dim_en, otp, uvlo;
  logic [CNT_W-1:0] toff_cyc, blank_cyc;
  logic gate;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  cot_switch_ctrl #(.CNT_W(CNT_W), .OC_HOLD_CYC(HOLD)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .peak_fix_i  (peak_fix),
    .peak_adj_i  (peak_adj),
    .ocp_i       (ocp),
    .dim_en_i    (dim_en),
    .otp_i       (otp),
    .uvlo_i      (uvlo),
    .toff_cyc_i  (toff_cyc),
    .blank_cyc_i (blank_cyc),
    .gate_o      (gate)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic count_level(input logic lvl, output int n);
    n = 0;
    while (gate == lvl && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_rise();
    int k;
    k = 0;
    while (gate != 1'b0 && k < 5000) begin @(negedge clk); k++; end
    while (gate != 1'b1 && k < 5000) begin @(negedge clk); k++; end
  endtask

  function automatic int atleast1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic park();
    @(negedge clk);
    dim_en = 1'b0; peak_fix = 1'b0; peak_adj = 1'b0; ocp = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int h, l, lows;
    rst_n = 1'b0; peak_fix = 1'b0; peak_adj = 1'b0; ocp = 1'b0;
    dim_en = 1'b1; otp = 1'b0; uvlo = 1'b0;
    toff_cyc = 16'd2; blank_cyc = 16'd3;
    repeat (4) @(negedge clk);
    chk("R9 gate in reset", int'(gate), 0);
    peak_fix = 1'b1;
    rst_n = 1'b1;
    wait_rise();
    chk("R9 rise after reset", int'(gate), 1);
    count_level(1'b1, h);
    chk("R9 first on phase blanked", h, 4);

    // R1 R2 R3 sweep, both peak inputs
    for (int sel = 0; sel < 2; sel++) begin
      for (int b = 0; b <= 4; b++) begin
        for (int t = 0; t <= 4; t++) begin
          park();
          blank_cyc = CNT_W'(b);
          toff_cyc  = CNT_W'(t);
          if (sel == 0) peak_fix = 1'b1; else peak_adj = 1'b1;
          dim_en = 1'b1;
          wait_rise();
          count_level(1'b1, h);
          chk(sel == 0 ? "R1 R2 on time fixed" : "R1 R2 on time adjust",
              h, atleast1(b) + 1);
          count_level(1'b0, l);
          chk("R3 off time", l, atleast1(t));
        end
      end
    end

    // R4 no trip: gate stays on
    park();
    blank_cyc = 16'd2; toff_cyc = 16'd2;
    dim_en = 1'b1;
    wait_rise();
    lows = 0;
    repeat (50) begin @(negedge clk); if (!gate) lows++; end
    chk("R4 stays on without trip", lows, 0);

    // R2 pulse inside blanking ignored
    park();
    blank_cyc = 16'd8;
    dim_en = 1'b1;
    wait_rise();
    peak_fix = 1'b1;
    @(negedge clk); peak_fix = 1'b0;
    lows = 0;
    repeat (30) begin @(negedge clk); if (!gate) lows++; end
    chk("R2 blanked pulse ignored", lows, 0);

    // R3 pulse inside off time ignored
    park();
    blank_cyc = 16'd2; toff_cyc = 16'd10;
    peak_fix = 1'b1; dim_en = 1'b1;
    wait_rise();
    count_level(1'b1, h);
    peak_fix = 1'b0;
    repeat (3) @(negedge clk);
    peak_fix = 1'b1;
    @(negedge clk); peak_fix = 1'b0;
    count_level(1'b0, l);
    chk("R3 off time with pulse", l + 4, 10);
    lows = 0;
    repeat (30) begin @(negedge clk); if (!gate) lows++; end
    chk("R3 off pulse ignored", lows, 0);

    // R5 dimming latency both ways
    park();
    blank_cyc = 16'd2; toff_cyc = 16'd2;
    dim_en = 1'b1;
    wait_rise();
    repeat (5) @(negedge clk);
    dim_en = 1'b0;
    @(negedge clk); chk("R5 off edge1", int'(gate), 1);
    @(negedge clk); chk("R5 off edge2", int'(gate), 1);
    @(negedge clk); chk("R5 off edge3", int'(gate), 0);
    lows = 0;
    repeat (20) begin @(negedge clk); if (!gate) lows++; end
    chk("R5 held off", lows, 20);
    dim_en = 1'b1;
    @(negedge clk); chk("R5 on edge1", int'(gate), 0);
    @(negedge clk); chk("R5 on edge2", int'(gate), 0);
    @(negedge clk); chk("R5 on edge3", int'(gate), 1);

    // R8 over-temperature and under-voltage
    for (int f = 0; f < 2; f++) begin
      repeat (5) @(negedge clk);
      if (f == 0) otp = 1'b1; else uvlo = 1'b1;
      @(negedge clk);
      @(negedge clk); chk("R8 fault edge2", int'(gate), 1);
      @(negedge clk); chk("R8 fault edge3", int'(gate), 0);
      lows = 0;
      repeat (20) begin @(negedge clk); if (!gate) lows++; end
      chk("R8 held off", lows, 20);
      otp = 1'b0; uvlo = 1'b0;
      @(negedge clk);
      @(negedge clk); chk("R8 release edge2", int'(gate), 0);
      @(negedge clk); chk("R8 release edge3", int'(gate), 1);
    end

    // R6 over-current hold-off
    repeat (10) @(negedge clk);
    ocp = 1'b1;
    @(negedge clk); ocp = 1'b0;
    @(negedge clk); chk("R6 ocp edge2", int'(gate), 1);
    @(negedge clk); chk("R6 ocp edge3", int'(gate), 0);
    count_level(1'b0, l);
    chk("R6 hold length", l, HOLD);
    lows = 0;
    repeat (20) begin @(negedge clk); if (!gate) lows++; end
    chk("R6 resumes", lows, 0);

    // R7 over-current and peak in the same cycle
    repeat (5) @(negedge clk);
    ocp = 1'b1; peak_fix = 1'b1;
    @(negedge clk); ocp = 1'b0; peak_fix = 1'b0;
    @(negedge clk);
    @(negedge clk); chk("R7 collision gate off", int'(gate), 0);
    count_level(1'b0, l);
    chk("R7 hold wins over off time", l, HOLD);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule